// File: doc/BRIEF.md
# Register Access Replay Sequencer

This block accepts one register request at a time from a CPU-side valid/ready port and turns it into a fixed run of APB transfers. The run is built so that a downstream asynchronous bridge always has the intended address latched before data moves. That bridge crosses into a register bank clocked by an independent 24 MHz clock, and it is known to latch addresses unreliably.

A write request becomes three transfers:

1. a throw-away read of the harmless offset 0x00;
2. the requested write;
3. the identical write once more.

A read request becomes two identical reads, and only the data of the second read goes back to the requester. When the `REPLAY_EN` parameter is 0 the workaround is off, and every request maps to one plain transfer.

The sequencer runs entirely in the APB clock domain. Errors signalled by the slave on any transfer of the run are gathered and reported with the single response for that request. The reset is synchronous and active high.

Top module: `regReplaySeq`

## Requirements
- R1: While `rst` is high at a clock edge, the block goes to idle. After that edge, `psel` and `penable` are 0, `reqReady` is 1, and `rspValid`, `rspDone` and `rspErr` are 0.
- R2: With `REPLAY_EN`=1, an accepted write (`reqWrite`=1) produces exactly three APB transfers, in this order: a read (`pwrite`=0) at `paddr`=0x00; then a write to `reqAddr` with `reqWdata`; then the same write again.
- R3: With `REPLAY_EN`=1, an accepted read produces exactly two APB reads at `reqAddr`. `rspRdata` carries the `prdata` of the second read, not the first.
- R4: Every transfer has exactly one setup cycle (`psel`=1, `penable`=0), followed by access cycles (`psel`=1, `penable`=1) that last until `pready`=1. `paddr`, `pwrite` and `pwdata` stay constant throughout the transfer.
- R5: `reqReady` is 1 only in idle. It is 0 from the cycle after acceptance until the response cycle has ended, so only one request is in flight.
- R6: A read completes with `rspValid` high for exactly one cycle, carrying the data. A write completes with `rspDone` high for exactly one cycle. The two are never high together, and `reqReady` is 1 in the cycle after the response.
- R7: If `pslverr` is 1 with `pready` on any transfer of a run, `rspErr` is 1 in that request's response. The flag is cleared when the next request is accepted.
- R8: With `REPLAY_EN`=0, each request produces exactly one transfer to `reqAddr` of its own direction, and a read returns that transfer's data.
- R9: A reset asserted in the middle of a run abandons it. No response for that run is ever produced, and the bus returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | ADDR_W | Register address |
| reqWdata | input | DATA_W | Write data |
| reqWrite | input | 1 | 1 = write, 0 = read |
| rspValid | output | 1 | Read response pulse |
| rspDone | output | 1 | Write completion pulse |
| rspRdata | output | DATA_W | Read data, valid with `rspValid` |
| rspErr | output | 1 | Slave error seen during the run |
| paddr | output | ADDR_W | APB address |
| psel | output | 1 | APB select |
| penable | output | 1 | APB enable |
| pwrite | output | 1 | APB direction |
| pwdata | output | DATA_W | APB write data |
| prdata | input | DATA_W | APB read data |
| pready | input | 1 | APB ready |
| pslverr | input | 1 | APB slave error |

## Verification
The last transfer of a run finishing can coincide with a slave error. In that one edge, three things happen together: the read data is captured, the sticky error flag is updated, and the machine moves into the response state. The response must carry both the data and the error.

The bench provokes this by making the slave flag the requested address, so the final transfer of a read errs, and it checks that `rspErr` is set in the same response. A separate case has only the dummy read err. That case shows the flag surviving the two later, clean writes, and then being cleared by the next clean request.

// File: rtl/regReplayPkg.sv
package regReplayPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_RESP   = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // request accepted this cycle
    logic xferDone;  // access phase completes this cycle
    logic isDummy;   // current transfer is the throw-away read
    logic lastXfer;  // current transfer is the final one of the run
  } seqCtl_t;

endpackage

// File: rtl/regReplayCtl.sv
module regReplayCtl
  import regReplayPkg::*;
#(
  parameter bit REPLAY_EN = 1'b1
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    pready,
  output logic    reqReady,
  output logic    psel,
  output logic    penable,
  output logic    rspValid,
  output logic    rspDone,
  output seqCtl_t ctl
);

  localparam int STEP_W = 2;

  seqState_t state, stateNext;
  logic [STEP_W-1:0] stepQ, lastQ, lastIdx;
  logic wrQ;
  logic accept;
  logic xferDone;
  logic atLast;

  // last step index depends on the replay variant
  generate
    if (REPLAY_EN) begin : g_replay
      assign lastIdx = reqWrite ? STEP_W'(2) : STEP_W'(1);
    end else begin : g_plain
      assign lastIdx = '0;
    end
  endgenerate

  assign accept   = reqValid && (state == ST_IDLE);
  assign xferDone = (state == ST_ACCESS) && pready;
  assign atLast   = (stepQ == lastQ);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (accept) stateNext = ST_SETUP;
      ST_SETUP:  stateNext = ST_ACCESS;
      ST_ACCESS: if (pready) stateNext = atLast ? ST_RESP : ST_SETUP;
      ST_RESP:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      stepQ <= '0;
      lastQ <= '0;
      wrQ   <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        stepQ <= '0;
        lastQ <= lastIdx;
        wrQ   <= reqWrite;
      end else if (xferDone && !atLast) begin
        stepQ <= stepQ + STEP_W'(1);
      end
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign psel     = (state == ST_SETUP) || (state == ST_ACCESS);
  assign penable  = (state == ST_ACCESS);
  assign rspValid = (state == ST_RESP) && !wrQ;
  assign rspDone  = (state == ST_RESP) && wrQ;

  assign ctl.capture  = accept;
  assign ctl.xferDone = xferDone;
  assign ctl.isDummy  = REPLAY_EN && wrQ && (stepQ == '0);
  assign ctl.lastXfer = atLast;

  // ---------------- assertions ----------------
  logic [2:0] chkCnt;
  logic [2:0] chkExp;
  always_ff @(posedge clk) begin
    if (rst) chkCnt <= '0;
    else if (accept) chkCnt <= '0;
    else if (xferDone) chkCnt <= chkCnt + 3'd1;
  end
  assign chkExp = REPLAY_EN ? (wrQ ? 3'd3 : 3'd2) : 3'd1;

  // R2, R3, R8: transfer count per run
  a_r2_xfer_count: assert property (@(posedge clk) disable iff (rst)
    (rspValid || rspDone) |-> (chkCnt == chkExp));

  a_r4_setup_then_access: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable) |=> (psel && penable));

  a_r4_hold_until_ready: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pready) |=> (psel && penable));

  a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    psel |-> !reqReady);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (rspValid || rspDone) |=> (!rspValid && !rspDone && reqReady));

  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(rspValid && rspDone));

endmodule

// File: rtl/regReplayDp.sv
module regReplayDp
  import regReplayPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] DUMMY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr,
  input  logic              psel,
  input  logic              penable,
  input  logic              pready,
  output logic [ADDR_W-1:0] paddr,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;
  logic              wrQ, errQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ  <= '0;
      wdataQ <= '0;
      wrQ    <= 1'b0;
      rdataQ <= '0;
      errQ   <= 1'b0;
    end else begin
      if (ctl.capture) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        wrQ    <= reqWrite;
        errQ   <= 1'b0;
      end else if (ctl.xferDone) begin
        errQ <= errQ | pslverr;
        if (ctl.lastXfer && !wrQ) rdataQ <= prdata;
      end
    end
  end

  assign paddr    = ctl.isDummy ? DUMMY_ADDR : addrQ;
  assign pwrite   = wrQ && !ctl.isDummy;
  assign pwdata   = wdataQ;
  assign rspRdata = rdataQ;
  assign rspErr   = errQ;

  a_r4_stable_bus: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pready) |=>
      ($stable(paddr) && $stable(pwrite) && $stable(pwdata)));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (rst)
    (errQ && !ctl.capture) |=> errQ);

  a_r7_err_seen: assert property (@(posedge clk) disable iff (rst)
    (ctl.xferDone && pslverr && !ctl.capture) |=> errQ);

endmodule

// File: rtl/regReplaySeq.sv
module regReplaySeq
  import regReplayPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter bit REPLAY_EN = 1'b1,
  parameter logic [ADDR_W-1:0] DUMMY_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqWrite,
  output logic              rspValid,
  output logic              rspDone,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr,
  output logic [ADDR_W-1:0] paddr,
  output logic              psel,
  output logic              penable,
  output logic              pwrite,
  output logic [DATA_W-1:0] pwdata,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pready,
  input  logic              pslverr
);

  seqCtl_t ctl;
  logic    rspErrRaw;

  regReplayCtl #(.REPLAY_EN(REPLAY_EN)) i_ctl (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .pready(pready), .reqReady(reqReady), .psel(psel), .penable(penable),
    .rspValid(rspValid), .rspDone(rspDone), .ctl(ctl)
  );

  regReplayDp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DUMMY_ADDR(DUMMY_ADDR)) i_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqWrite(reqWrite), .prdata(prdata), .pslverr(pslverr), .psel(psel),
    .penable(penable), .pready(pready), .paddr(paddr), .pwrite(pwrite),
    .pwdata(pwdata), .rspRdata(rspRdata), .rspErr(rspErrRaw)
  );

  // error is only reported alongside a response
  assign rspErr = rspErrRaw && (rspValid || rspDone);

  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!psel && !penable && reqReady && !rspValid && !rspDone));

endmodule

// File: tb/test_regReplaySeq.sv
module apbModel #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  output logic          pready,
  output logic          pslverr,
  input  int            waitN,
  input  logic          errEn,
  input  logic [AW-1:0] errAddr
);
  logic [DW-1:0] mem [16];
  int waitCtr, setupCtr, readCnt, logN;
  logic [AW-1:0] logAddr  [64];
  logic          logWrite [64];
  logic [DW-1:0] logWdata [64];
  int            logSetup [64];
  int            logAcc   [64];

  assign pready  = psel && penable && (waitCtr >= waitN);
  assign prdata  = pready ? (mem[paddr[5:2]] + DW'(readCnt)) : '0;
  assign pslverr = pready && errEn && (paddr == errAddr);

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) mem[i] <= DW'(32'hA000_0000 + i * 32'h111);
      waitCtr <= 0; setupCtr <= 0; readCnt <= 0; logN <= 0;
    end else begin
      if (psel && !penable) setupCtr <= setupCtr + 1;
      if (psel && penable) begin
        if (pready) begin
          logAddr[logN]  <= paddr;
          logWrite[logN] <= pwrite;
          logWdata[logN] <= pwdata;
          logSetup[logN] <= setupCtr;
          logAcc[logN]   <= waitCtr + 1;
          logN <= logN + 1;
          if (pwrite) mem[paddr[5:2]] <= pwdata;
          else readCnt <= readCnt + 1;
          waitCtr <= 0; setupCtr <= 0;
        end else begin
          waitCtr <= waitCtr + 1;
        end
      end
    end
  end
endmodule

module test_regReplaySeq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          reqValidA = 1'b0, reqValidB = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqWrite = 1'b0;
  int            waitN = 0;
  logic          errEn = 1'b0;
  logic [AW-1:0] errAddr = '0;

  logic readyA, rvA, rdA, errA, pselA, penA, pwrA, preadyA, pslvA;
  logic [DW-1:0] rdataA, pwdA, prdA;
  logic [AW-1:0] paddrA;
  logic readyB, rvB, rdB, errB, pselB, penB, pwrB, preadyB, pslvB;
  logic [DW-1:0] rdataB, pwdB, prdB;
  logic [AW-1:0] paddrB;

  regReplaySeq #(.ADDR_W(AW), .DATA_W(DW), .REPLAY_EN(1'b1)) i_regReplaySeq (
    .clk(clk), .rst(rst), .reqValid(reqValidA), .reqReady(readyA),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqWrite(reqWrite),
    .rspValid(rvA), .rspDone(rdA), .rspRdata(rdataA), .rspErr(errA),
    .paddr(paddrA), .psel(pselA), .penable(penA), .pwrite(pwrA), .pwdata(pwdA),
    .prdata(prdA), .pready(preadyA), .pslverr(pslvA));

  apbModel #(.AW(AW), .DW(DW)) i_mdlA (
    .clk(clk), .rst(rst), .psel(pselA), .penable(penA), .pwrite(pwrA),
    .paddr(paddrA), .pwdata(pwdA), .prdata(prdA), .pready(preadyA),
    .pslverr(pslvA), .waitN(waitN), .errEn(errEn), .errAddr(errAddr));

  regReplaySeq #(.ADDR_W(AW), .DATA_W(DW), .REPLAY_EN(1'b0)) i_regReplaySeq_single (
    .clk(clk), .rst(rst), .reqValid(reqValidB), .reqReady(readyB),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqWrite(reqWrite),
    .rspValid(rvB), .rspDone(rdB), .rspRdata(rdataB), .rspErr(errB),
    .paddr(paddrB), .psel(pselB), .penable(penB), .pwrite(pwrB), .pwdata(pwdB),
    .prdata(prdB), .pready(preadyB), .pslverr(pslvB));

  apbModel #(.AW(AW), .DW(DW)) i_mdlB (
    .clk(clk), .rst(rst), .psel(pselB), .penable(penB), .pwrite(pwrB),
    .paddr(paddrB), .pwdata(pwdB), .prdata(prdB), .pready(preadyB),
    .pslverr(pslvB), .waitN(waitN), .errEn(errEn), .errAddr(errAddr));

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one request on instance A (useB=0) or B (useB=1)
  task automatic doReq(input bit useB, input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, output logic [DW-1:0] rdOut,
                       output logic errOut, output bit gotDone, output bit gotValid);
    bit busyBad = 1'b0;
    bit seen = 1'b0;
    @(negedge clk);
    reqAddr = a; reqWdata = d; reqWrite = wr;
    if (useB) reqValidB = 1'b1; else reqValidA = 1'b1;
    while (!(useB ? readyB : readyA)) @(negedge clk);
    @(negedge clk);
    reqValidA = 1'b0; reqValidB = 1'b0;
    for (int i = 0; i < 300 && !seen; i++) begin
      if (useB ? (rvB || rdB) : (rvA || rdA)) begin
        seen = 1'b1;
        rdOut = useB ? rdataB : rdataA;
        errOut = useB ? errB : errA;
        gotDone = useB ? rdB : rdA;
        gotValid = useB ? rvB : rvA;
      end else begin
        if (useB ? readyB : readyA) busyBad = 1'b1;
        @(negedge clk);
      end
    end
    check(seen, "R6", "response arrives", 64'(seen), 64'd1);
    check(!busyBad, "R5", "ready low while busy", 64'(busyBad), 64'd0);
    @(negedge clk);
    check((useB ? (readyB && !rvB && !rdB) : (readyA && !rvA && !rdA)), "R6",
          "single pulse then ready", 64'(useB ? readyB : readyA), 64'd1);
  endtask

  task automatic tReset();
    @(negedge clk);
    check(readyA && !pselA && !penA, "R1", "idle bus after reset",
          {61'd0, readyA, pselA, penA}, 64'b100);
    check(!rvA && !rdA && !errA, "R1", "no response after reset",
          {61'd0, rvA, rdA, errA}, 64'd0);
  endtask

  task automatic tWrite();
    logic [DW-1:0] r; logic e; bit dn, vl;
    int b = i_mdlA.logN;
    doReq(1'b0, 1'b1, 16'h0014, 32'hCAFE_0001, r, e, dn, vl);
    check(i_mdlA.logN - b == 3, "R2", "write transfer count", 64'(i_mdlA.logN - b), 64'd3);
    check(i_mdlA.logAddr[b] == 16'h0000 && !i_mdlA.logWrite[b], "R2", "dummy read at 0",
          {47'd0, i_mdlA.logWrite[b], i_mdlA.logAddr[b]}, 64'd0);
    for (int k = 1; k < 3; k++)
      check(i_mdlA.logAddr[b+k] == 16'h0014 && i_mdlA.logWrite[b+k] &&
            i_mdlA.logWdata[b+k] == 32'hCAFE_0001, "R2", "repeated write",
            {15'd0, i_mdlA.logWrite[b+k], i_mdlA.logAddr[b+k], i_mdlA.logWdata[b+k]},
            {15'd0, 1'b1, 16'h0014, 32'hCAFE_0001});
    check(dn && !vl && !e, "R6", "write gives done only", {61'd0, dn, vl, e}, 64'b100);
  endtask

  task automatic tRead();
    logic [DW-1:0] r; logic e; bit dn, vl;
    int b = i_mdlA.logN;
    int rc = i_mdlA.readCnt;
    logic [DW-1:0] base = i_mdlA.mem[2];
    doReq(1'b0, 1'b0, 16'h0008, '0, r, e, dn, vl);
    check(i_mdlA.logN - b == 2, "R3", "read transfer count", 64'(i_mdlA.logN - b), 64'd2);
    for (int k = 0; k < 2; k++)
      check(i_mdlA.logAddr[b+k] == 16'h0008 && !i_mdlA.logWrite[b+k], "R3", "read address",
            {47'd0, i_mdlA.logWrite[b+k], i_mdlA.logAddr[b+k]}, 64'h0008);
    check(r == base + DW'(rc + 1), "R3", "second read data returned", 64'(r), 64'(base + DW'(rc + 1)));
    check(vl && !dn && !e, "R6", "read gives valid only", {61'd0, dn, vl, e}, 64'b010);
  endtask

  task automatic tWait();
    logic [DW-1:0] r; logic e; bit dn, vl;
    int b = i_mdlA.logN;
    waitN = 3;
    doReq(1'b0, 1'b1, 16'h0018, 32'h1234_5678, r, e, dn, vl);
    waitN = 0;
    for (int k = 0; k < 3; k++) begin
      check(i_mdlA.logSetup[b+k] == 1, "R4", "one setup cycle", 64'(i_mdlA.logSetup[b+k]), 64'd1);
      check(i_mdlA.logAcc[b+k] == 4, "R4", "access held until ready", 64'(i_mdlA.logAcc[b+k]), 64'd4);
    end
    check(i_mdlA.mem[6] == 32'h1234_5678, "R2", "data landed", 64'(i_mdlA.mem[6]), 64'h1234_5678);
  endtask

  task automatic tErr();
    logic [DW-1:0] r; logic e; bit dn, vl;
    errEn = 1'b1; errAddr = 16'h0000;       // only the dummy read errs
    doReq(1'b0, 1'b1, 16'h0020, 32'h5, r, e, dn, vl);
    check(e, "R7", "dummy-read error kept", 64'(e), 64'd1);
    errAddr = 16'h0030;                     // final read errs too
    doReq(1'b0, 1'b0, 16'h0030, '0, r, e, dn, vl);
    check(e && vl, "R7", "last-transfer error with data", {62'd0, e, vl}, 64'b11);
    errEn = 1'b0;
    doReq(1'b0, 1'b0, 16'h0030, '0, r, e, dn, vl);
    check(!e, "R7", "flag cleared on next request", 64'(e), 64'd0);
  endtask

  task automatic tSingle();
    logic [DW-1:0] r; logic e; bit dn, vl;
    int b = i_mdlB.logN;
    int rc;
    logic [DW-1:0] base;
    doReq(1'b1, 1'b1, 16'h0010, 32'h0BAD_F00D, r, e, dn, vl);
    check(i_mdlB.logN - b == 1 && i_mdlB.logWrite[b] && i_mdlB.logAddr[b] == 16'h0010,
          "R8", "single write", 64'(i_mdlB.logN - b), 64'd1);
    b = i_mdlB.logN; rc = i_mdlB.readCnt; base = i_mdlB.mem[3];
    doReq(1'b1, 1'b0, 16'h000C, '0, r, e, dn, vl);
    check(i_mdlB.logN - b == 1 && !i_mdlB.logWrite[b], "R8", "single read",
          64'(i_mdlB.logN - b), 64'd1);
    check(r == base + DW'(rc), "R8", "single read data", 64'(r), 64'(base + DW'(rc)));
  endtask

  task automatic tResetMid();
    bit sawRsp = 1'b0;
    waitN = 6;
    @(negedge clk);
    reqAddr = 16'h0004; reqWrite = 1'b1; reqWdata = 32'h77; reqValidA = 1'b1;
    @(negedge clk); reqValidA = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; waitN = 0;
    check(!pselA && !penA && readyA, "R9", "bus idle after mid reset",
          {61'd0, pselA, penA, readyA}, 64'b001);
    for (int i = 0; i < 20; i++) begin
      if (rvA || rdA || pselA) sawRsp = 1'b1;
      @(negedge clk);
    end
    check(!sawRsp, "R9", "abandoned run stays silent", 64'(sawRsp), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tReset();
    tWrite();
    tRead();
    tWait();
    tErr();
    tSingle();
    tResetMid();
    tRead();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule